// File: doc/BRIEF.md
# ALU Self-Test Sequencer

This block exercises an external 32-bit ALU against a built-in table of seventeen test vectors. Each table entry carries two operands, a 6-bit operation code and the correct result together with the correct zero, overflow and negative flags. When started in automatic mode, the sequencer feeds each vector to the ALU and holds it for a programmable number of cycles, so that a person can follow the run on lamps. It compares what the ALU returns with the stored answer and lights a pass lamp or a fail lamp. The index of the vector under test is shown throughout.

A fault-inject switch flips the least significant bit of the ALU result on its way into the comparator. This shows that the checker catches a wrong result by disagreement with a correct answer key. Neither the ALU nor the key is altered. A sticky failure bit records whether any vector failed since the last start. At the end of a run the block shows a done flag and an overall pass flag. In manual mode the sequencer stays out of the way: the ALU operand and operation lines follow the external switches, and the sequencer waits idle.

Top module: `alu_selftest_seq`

## Requirements
- R1: After a synchronous active-low reset, test_id is 0 and pass_led, fail_led, done, all_pass and any_fail are all low.
- R2: A start pulse while auto_mode is high and the sequencer is idle or done begins at vector 0. test_id then rises by exactly one per vector up to 16. Each vector is held for DWELL_CYCLES+2 cycles: one apply cycle, DWELL_CYCLES check cycles and one advance cycle.
- R3: Both lamps stay low during a vector's apply cycle and its first check cycle. From then on exactly one lamp is lit for DWELL_CYCLES cycles. pass_led means the observed result and the z, v and n flags all equal the stored values.
- R4: While fault_inj is high, the comparator sees the ALU result with bit 0 inverted, and every vector is reported as a failure. The stored answers are unchanged, so a later run without the fault passes every vector.
- R5: The stored flags follow this contract: z is high when the result is zero, n equals result bit 31, and v is high only for a signed overflow of add or subtract.
- R6: any_fail goes high in the cycle that a fail verdict is first shown. It stays high, including through the done state and manual mode, until a start pulse begins a new run.
- R7: After the last vector's advance cycle, done is high, test_id holds 16, both lamps are low and all_pass equals the inverse of any_fail. This state lasts until a start pulse.
- R8: While auto_mode is low, alu_a, alu_b and alu_fn equal sw_a, sw_b and sw_fn. The sequencer returns to idle one cycle later, with lamps and done low, and a start pulse has no effect.
- R9: The table covers all thirteen operations, using these codes for alu_fn: ADD 0x00, SUB 0x01, MUL 0x02, AND 0x18, XOR 0x16, PASSA 0x1A, OR 0x1E, SHL 0x20, SHR 0x21, SRA 0x23, CMPEQ 0x33, CMPLT 0x35, CMPLE 0x37. Shift amounts are taken from operand B bits 4:0. The table includes positive and negative overflow for ADD and a signed overflow for SUB.
- R10: A start pulse during a run neither restarts nor disturbs the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| auto_mode | input | 1 | High: table-driven testing; low: switches drive the ALU |
| start | input | 1 | One-cycle pulse that begins a run from vector 0 |
| fault_inj | input | 1 | Inverts result bit 0 before the comparison |
| sw_a | input | 32 | Manual operand A |
| sw_b | input | 32 | Manual operand B |
| sw_fn | input | 6 | Manual operation code |
| alu_res | input | 32 | Result returned by the ALU |
| alu_z | input | 1 | Zero flag from the ALU |
| alu_v | input | 1 | Overflow flag from the ALU |
| alu_n | input | 1 | Negative flag from the ALU |
| alu_a | output | 32 | Operand A to the ALU |
| alu_b | output | 32 | Operand B to the ALU |
| alu_fn | output | 6 | Operation code to the ALU |
| test_id | output | 5 | Index of the vector under test |
| pass_led | output | 1 | Current vector matched its stored answer |
| fail_led | output | 1 | Current vector did not match |
| done | output | 1 | Run finished |
| all_pass | output | 1 | Run finished with no failure |
| any_fail | output | 1 | Sticky: a failure was seen in this run |

## Verification
The assertions assume that the ALU answers combinationally within one cycle of a vector being applied. They also assume that fault_inj is held steady during a vector's check window, so that a pass verdict can always be traced to a cycle with no fault. The bench models the ALU as a pure combinational function of the sequencer's operand and operation outputs. It changes fault_inj, auto_mode and start only on falling edges and only between runs, apart from the deliberate mid-run start pulse. The bench derives expected verdicts from its own ALU model and the fault setting, never from the stored table.

// File: rtl/alu_seq_pkg.sv
// Shared constants, operation codes and types for the ALU self-test sequencer.
// Assumes a 32-bit ALU with a 6-bit operation code.
package alu_seq_pkg;
    localparam int DATA_W = 32;
    localparam int FN_W   = 6;
    localparam int N_VEC  = 17;
    localparam int ID_W   = $clog2(N_VEC);

    localparam logic [FN_W-1:0] OP_ADD   = 6'h00;
    localparam logic [FN_W-1:0] OP_SUB   = 6'h01;
    localparam logic [FN_W-1:0] OP_MUL   = 6'h02;
    localparam logic [FN_W-1:0] OP_AND   = 6'h18;
    localparam logic [FN_W-1:0] OP_XOR   = 6'h16;
    localparam logic [FN_W-1:0] OP_PASSA = 6'h1A;
    localparam logic [FN_W-1:0] OP_OR    = 6'h1E;
    localparam logic [FN_W-1:0] OP_SHL   = 6'h20;
    localparam logic [FN_W-1:0] OP_SHR   = 6'h21;
    localparam logic [FN_W-1:0] OP_SRA   = 6'h23;
    localparam logic [FN_W-1:0] OP_CMPEQ = 6'h33;
    localparam logic [FN_W-1:0] OP_CMPLT = 6'h35;
    localparam logic [FN_W-1:0] OP_CMPLE = 6'h37;

    // One table entry: stimulus plus the correct answer and flags.
    typedef struct packed {
        logic [DATA_W-1:0] a;
        logic [DATA_W-1:0] b;
        logic [FN_W-1:0]   fn;
        logic [DATA_W-1:0] res;
        logic              z;
        logic              v;
        logic              n;
    } vec_t;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_APPLY = 3'd1,
        ST_CHECK = 3'd2,
        ST_NEXT  = 3'd3,
        ST_DONE  = 3'd4
    } seq_state_e;

    // Builds a table entry from its fields.
    function automatic vec_t mk_vec(input logic [DATA_W-1:0] a,
                                    input logic [DATA_W-1:0] b,
                                    input logic [FN_W-1:0]   fn,
                                    input logic [DATA_W-1:0] res,
                                    input logic              z,
                                    input logic              v,
                                    input logic              n);
        vec_t e;
        e.a   = a;
        e.b   = b;
        e.fn  = fn;
        e.res = res;
        e.z   = z;
        e.v   = v;
        e.n   = n;
        return e;
    endfunction
endpackage

// File: rtl/alu_vec_rom.sv
// Constant test-vector table. Every entry holds the correct answer and flags.
// Assumes idx is below N_VEC; other indices return an all-zero entry.
module alu_vec_rom
    import alu_seq_pkg::*;
(
    input  logic [ID_W-1:0] idx,
    output vec_t            vec
);
    // Purpose: look up the entry selected by idx.
    always_comb begin
        case (idx)
            5'd0:  vec = mk_vec(32'h0000_0005, 32'h0000_0007, OP_ADD,   32'h0000_000C, 1'b0, 1'b0, 1'b0);
            5'd1:  vec = mk_vec(32'h7FFF_FFFF, 32'h0000_0001, OP_ADD,   32'h8000_0000, 1'b0, 1'b1, 1'b1);
            5'd2:  vec = mk_vec(32'h8000_0000, 32'hFFFF_FFFF, OP_ADD,   32'h7FFF_FFFF, 1'b0, 1'b1, 1'b0);
            5'd3:  vec = mk_vec(32'h0000_0005, 32'h0000_0005, OP_SUB,   32'h0000_0000, 1'b1, 1'b0, 1'b0);
            5'd4:  vec = mk_vec(32'h8000_0000, 32'h0000_0001, OP_SUB,   32'h7FFF_FFFF, 1'b0, 1'b1, 1'b0);
            5'd5:  vec = mk_vec(32'h0000_0003, 32'h0000_0008, OP_SUB,   32'hFFFF_FFFB, 1'b0, 1'b0, 1'b1);
            5'd6:  vec = mk_vec(32'h0000_0006, 32'h0000_0007, OP_MUL,   32'h0000_002A, 1'b0, 1'b0, 1'b0);
            5'd7:  vec = mk_vec(32'hF0F0_F0F0, 32'h0FF0_0FF0, OP_AND,   32'h00F0_00F0, 1'b0, 1'b0, 1'b0);
            5'd8:  vec = mk_vec(32'h0000_FF00, 32'h00FF_0000, OP_OR,    32'h00FF_FF00, 1'b0, 1'b0, 1'b0);
            5'd9:  vec = mk_vec(32'hFFFF_0000, 32'hFF00_FF00, OP_XOR,   32'h00FF_FF00, 1'b0, 1'b0, 1'b0);
            5'd10: vec = mk_vec(32'h1234_5678, 32'h0000_DEAD, OP_PASSA, 32'h1234_5678, 1'b0, 1'b0, 1'b0);
            5'd11: vec = mk_vec(32'h0000_0001, 32'h0000_0004, OP_SHL,   32'h0000_0010, 1'b0, 1'b0, 1'b0);
            5'd12: vec = mk_vec(32'h8000_0000, 32'h0000_0001, OP_SHR,   32'h4000_0000, 1'b0, 1'b0, 1'b0);
            5'd13: vec = mk_vec(32'h8000_0000, 32'h0000_0004, OP_SRA,   32'hF800_0000, 1'b0, 1'b0, 1'b1);
            5'd14: vec = mk_vec(32'h0000_0009, 32'h0000_0009, OP_CMPEQ, 32'h0000_0001, 1'b0, 1'b0, 1'b0);
            5'd15: vec = mk_vec(32'hFFFF_FFFF, 32'h0000_0001, OP_CMPLT, 32'h0000_0001, 1'b0, 1'b0, 1'b0);
            5'd16: vec = mk_vec(32'h0000_0005, 32'h0000_0004, OP_CMPLE, 32'h0000_0000, 1'b1, 1'b0, 1'b0);
            default: vec = '0;
        endcase
    end
endmodule

// File: rtl/alu_result_cmp.sv
// Fault-inject stage and comparator. Inverts bit 0 of the ALU result when
// fault_inj is high, then checks result and flags against the stored answer.
// Assumes the ALU outputs are settled when the match is sampled.
module alu_result_cmp
    import alu_seq_pkg::*;
(
    input  vec_t              expv,
    input  logic [DATA_W-1:0] obs_res,
    input  logic              obs_z,
    input  logic              obs_v,
    input  logic              obs_n,
    input  logic              fault_inj,
    output logic              match
);
    logic [DATA_W-1:0] seen_res;

    // Purpose: corrupt the observed result when a fault is requested.
    always_comb begin
        seen_res    = obs_res;
        seen_res[0] = obs_res[0] ^ fault_inj;
    end

    // Purpose: flag agreement of the result and all three flags.
    always_comb begin
        match = (seen_res == expv.res) && (obs_z == expv.z)
             && (obs_v == expv.v) && (obs_n == expv.n);
    end
endmodule

// File: rtl/alu_seq_ctrl.sv
// Run controller: steps the vector index, times the dwell of each vector,
// registers the verdict and keeps the sticky failure bit.
// Assumes match is valid one cycle after the index changes.
module alu_seq_ctrl
    import alu_seq_pkg::*;
#(
    parameter int DWELL_CYCLES = 25_000_000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            auto_mode,
    input  logic            start,
    input  logic            match,
    output logic [ID_W-1:0] idx,
    output logic            pass_q,
    output logic            fail_q,
    output logic            done,
    output logic            any_fail
);
    localparam int              CNT_W   = $clog2(DWELL_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_END = CNT_W'(DWELL_CYCLES - 1);
    localparam logic [ID_W-1:0]  ID_LAST = ID_W'(N_VEC - 1);

    seq_state_e       state_q;
    logic [CNT_W-1:0] cnt_q;
    logic [ID_W-1:0]  idx_q;
    logic             any_fail_q;

    // Purpose: state sequencing, dwell timing, verdict and sticky fail.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            cnt_q      <= '0;
            idx_q      <= '0;
            pass_q     <= 1'b0;
            fail_q     <= 1'b0;
            any_fail_q <= 1'b0;
        end else if (!auto_mode) begin
            state_q <= ST_IDLE;
            pass_q  <= 1'b0;
            fail_q  <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE, ST_DONE: begin
                    pass_q <= 1'b0;
                    fail_q <= 1'b0;
                    if (start) begin
                        idx_q      <= '0;
                        cnt_q      <= '0;
                        any_fail_q <= 1'b0;
                        state_q    <= ST_APPLY;
                    end
                end
                ST_APPLY: begin
                    pass_q  <= 1'b0;
                    fail_q  <= 1'b0;
                    cnt_q   <= '0;
                    state_q <= ST_CHECK;
                end
                ST_CHECK: begin
                    pass_q <= match;
                    fail_q <= !match;
                    if (!match) any_fail_q <= 1'b1;
                    if (cnt_q == CNT_END) state_q <= ST_NEXT;
                    else                  cnt_q   <= cnt_q + CNT_W'(1);
                end
                ST_NEXT: begin
                    pass_q <= 1'b0;
                    fail_q <= 1'b0;
                    if (idx_q == ID_LAST) begin
                        state_q <= ST_DONE;
                    end else begin
                        idx_q   <= idx_q + ID_W'(1);
                        state_q <= ST_APPLY;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign idx      = idx_q;
    assign done     = (state_q == ST_DONE);
    assign any_fail = any_fail_q;

    // R2
    id_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_q != $past(idx_q)) |-> (idx_q == $past(idx_q) + ID_W'(1) || idx_q == '0));

    // R3
    apply_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_APPLY) |=> (!pass_q && !fail_q));

    // R6
    sticky_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (any_fail_q && !start) |=> any_fail_q);

    // R6
    fail_marks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fail_q |-> any_fail_q);

    // R7
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DONE && !start && auto_mode) |=> (state_q == ST_DONE && $stable(idx_q)));

    // R8
    manual_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !auto_mode |=> (state_q == ST_IDLE && !pass_q && !fail_q));
endmodule

// File: rtl/alu_selftest_seq.sv
// Top of the ALU self-test sequencer: selects switch or table operands for
// the external ALU, compares its answer and shows the verdict.
// Assumes the external ALU is combinational with a single-cycle settle time.
module alu_selftest_seq
    import alu_seq_pkg::*;
#(
    parameter int DWELL_CYCLES = 25_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              auto_mode,
    input  logic              start,
    input  logic              fault_inj,
    input  logic [DATA_W-1:0] sw_a,
    input  logic [DATA_W-1:0] sw_b,
    input  logic [FN_W-1:0]   sw_fn,
    input  logic [DATA_W-1:0] alu_res,
    input  logic              alu_z,
    input  logic              alu_v,
    input  logic              alu_n,
    output logic [DATA_W-1:0] alu_a,
    output logic [DATA_W-1:0] alu_b,
    output logic [FN_W-1:0]   alu_fn,
    output logic [ID_W-1:0]   test_id,
    output logic              pass_led,
    output logic              fail_led,
    output logic              done,
    output logic              all_pass,
    output logic              any_fail
);
    vec_t cur_vec;
    logic match;

    alu_vec_rom u_rom (
        .idx (test_id),
        .vec (cur_vec)
    );

    alu_result_cmp u_cmp (
        .expv      (cur_vec),
        .obs_res   (alu_res),
        .obs_z     (alu_z),
        .obs_v     (alu_v),
        .obs_n     (alu_n),
        .fault_inj (fault_inj),
        .match     (match)
    );

    alu_seq_ctrl #(
        .DWELL_CYCLES (DWELL_CYCLES)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .auto_mode (auto_mode),
        .start     (start),
        .match     (match),
        .idx       (test_id),
        .pass_q    (pass_led),
        .fail_q    (fail_led),
        .done      (done),
        .any_fail  (any_fail)
    );

    // Purpose: route table or switch values to the ALU inputs.
    always_comb begin
        if (auto_mode) begin
            alu_a  = cur_vec.a;
            alu_b  = cur_vec.b;
            alu_fn = cur_vec.fn;
        end else begin
            alu_a  = sw_a;
            alu_b  = sw_b;
            alu_fn = sw_fn;
        end
    end

    // Purpose: overall verdict at the end of a run.
    assign all_pass = done && !any_fail;

    // R4
    fault_never_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pass_led |-> !$past(fault_inj));

    // R7
    done_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!pass_led && !fail_led));
endmodule

// File: tb/tb_alu_selftest_seq.sv
// Scoreboard bench: a driver task queues expected verdicts per vector, a
// monitor pops and compares them as the sequencer shows each verdict.
module tb_alu_selftest_seq;
    localparam int DW    = 5;
    localparam int NV    = 17;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        auto_mode = 1'b1;
    logic        start = 1'b0;
    logic        fault_inj = 1'b0;
    logic [31:0] sw_a = '0, sw_b = '0;
    logic [5:0]  sw_fn = '0;
    logic [31:0] alu_res;
    logic        alu_z, alu_v, alu_n;
    logic [31:0] alu_a, alu_b;
    logic [5:0]  alu_fn;
    logic [4:0]  test_id;
    logic        pass_led, fail_led, done, all_pass, any_fail;

    int total = 0;
    int bad   = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    alu_selftest_seq #(.DWELL_CYCLES(DW)) dut (
        .clk(clk), .rst_n(rst_n), .auto_mode(auto_mode), .start(start),
        .fault_inj(fault_inj), .sw_a(sw_a), .sw_b(sw_b), .sw_fn(sw_fn),
        .alu_res(alu_res), .alu_z(alu_z), .alu_v(alu_v), .alu_n(alu_n),
        .alu_a(alu_a), .alu_b(alu_b), .alu_fn(alu_fn), .test_id(test_id),
        .pass_led(pass_led), .fail_led(fail_led), .done(done),
        .all_pass(all_pass), .any_fail(any_fail)
    );

    // Bench ALU model: {res, z, v, n} from the R9 codes and R5 flag contract.
    function automatic logic [34:0] ref_alu(input logic [31:0] a, input logic [31:0] b,
                                            input logic [5:0] fn);
        logic [31:0] r;
        logic        v;
        v = 1'b0;
        case (fn)
            6'h00: begin r = a + b; v = (a[31] == b[31]) && (r[31] != a[31]); end
            6'h01: begin r = a - b; v = (a[31] != b[31]) && (r[31] != a[31]); end
            6'h02: r = a * b;
            6'h18: r = a & b;
            6'h1E: r = a | b;
            6'h16: r = a ^ b;
            6'h1A: r = a;
            6'h20: r = a << b[4:0];
            6'h21: r = a >> b[4:0];
            6'h23: r = $unsigned($signed(a) >>> b[4:0]);
            6'h33: r = {31'b0, a == b};
            6'h35: r = {31'b0, $signed(a) < $signed(b)};
            6'h37: r = {31'b0, $signed(a) <= $signed(b)};
            default: r = '0;
        endcase
        return {r, (r == 32'b0), v, r[31]};
    endfunction

    assign {alu_res, alu_z, alu_v, alu_n} = ref_alu(alu_a, alu_b, alu_fn);

    function automatic int op_bit(input logic [5:0] fn);
        case (fn)
            6'h00: return 0;  6'h01: return 1;  6'h02: return 2;
            6'h18: return 3;  6'h1E: return 4;  6'h16: return 5;
            6'h1A: return 6;  6'h20: return 7;  6'h21: return 8;
            6'h23: return 9;  6'h33: return 10; 6'h35: return 11;
            6'h37: return 12; default: return 13;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    typedef struct {
        int id;
        bit exp_pass;
    } sb_item_t;
    sb_item_t sb_q[$];

    bit        mon_en  = 0;
    bit        have_id = 0;
    int        cur_id  = 0;
    int        vis_len = 0;
    logic [13:0] op_seen = '0;
    bit        add_pos_ovf = 0, add_neg_ovf = 0, sub_ovf = 0;

    // Monitor: pop one expected item per newly shown verdict.
    always @(negedge clk) begin
        if (mon_en && (pass_led || fail_led)) begin
            if (!have_id || int'(test_id) != cur_id) begin
                if (have_id) chk(vis_len == DW, "R3 verdict dwell", vis_len, DW);
                if (sb_q.size() == 0) begin
                    chk(0, "R2 unexpected verdict", test_id, 0);
                end else begin
                    sb_item_t it;
                    logic [34:0] m;
                    it = sb_q.pop_front();
                    chk(int'(test_id) == it.id, "R2 test id order", test_id, it.id);
                    chk(pass_led == it.exp_pass && fail_led == !it.exp_pass,
                        it.exp_pass ? "R3 pass lamp" : "R4 fault fail lamp",
                        {pass_led, fail_led}, {it.exp_pass, !it.exp_pass});
                    m = ref_alu(alu_a, alu_b, alu_fn);
                    op_seen[op_bit(alu_fn)] = 1'b1;
                    if (alu_fn == 6'h00 && m[1] && !alu_a[31]) add_pos_ovf = 1;
                    if (alu_fn == 6'h00 && m[1] &&  alu_a[31]) add_neg_ovf = 1;
                    if (alu_fn == 6'h01 && m[1]) sub_ovf = 1;
                end
                cur_id  = int'(test_id);
                have_id = 1;
                vis_len = 1;
            end else begin
                vis_len++;
            end
        end
    end

    task automatic wait_done(input int limit);
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            if (done) break;
        end
    endtask

    // Driver: queue expected verdicts, start a run, poke start mid-run.
    task automatic run_auto(input bit flt);
        int first_seen;
        @(negedge clk);
        fault_inj = flt;
        for (int i = 0; i < NV; i++) sb_q.push_back('{id: i, exp_pass: !flt});
        have_id = 0;
        mon_en  = 1;
        start   = 1'b1;
        @(negedge clk);
        start   = 1'b0;
        // R2: the run begins at vector 0, its verdict appearing after APPLY and one CHECK.
        first_seen = 0;
        for (int i = 0; i < 3; i++) begin
            if ((pass_led || fail_led) && first_seen == 0) first_seen = i + 1;
            @(negedge clk);
        end
        chk(test_id == 5'd0 || test_id == 5'd1, "R2 starts at vector 0", test_id, 0);
        chk(first_seen == 3, "R3 verdict latency", first_seen, 3);
        repeat (3 * (DW + 2)) @(negedge clk);
        // R10: start pulse mid-run must be ignored
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done(NV * (DW + 2) + 20);
        chk(done == 1'b1, "R7 done reached", done, 1);
        chk(vis_len == DW, "R3 last verdict dwell", vis_len, DW);
        chk(sb_q.size() == 0, "R10 all vectors once", sb_q.size(), 0);
        mon_en = 0;
        chk(test_id == 5'd16, "R7 id holds last", test_id, 16);
        chk(!pass_led && !fail_led, "R7 lamps dark", {pass_led, fail_led}, 0);
        chk(any_fail == flt, "R6 sticky fail", any_fail, flt);
        chk(all_pass == !flt, "R7 all_pass", all_pass, !flt);
        fault_inj = 1'b0;
    endtask

    initial begin
        #(8 * 100000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(test_id == 0 && !pass_led && !fail_led, "R1 reset id/lamps", {test_id, pass_led, fail_led}, 0);
        chk(!done && !all_pass && !any_fail, "R1 reset flags", {done, all_pass, any_fail}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        run_auto(1'b0);
        chk(op_seen[12:0] == 13'h1FFF, "R9 all operations covered", op_seen, 14'h1FFF);
        chk(add_pos_ovf && add_neg_ovf && sub_ovf, "R9 overflow cases", {add_pos_ovf, add_neg_ovf, sub_ovf}, 3'b111);

        run_auto(1'b1);
        repeat (5) @(negedge clk);
        chk(done && any_fail && test_id == 5'd16, "R7 done holds after fault run", {done, any_fail}, 2'b11);

        // R8: manual mode
        auto_mode = 1'b0;
        sw_a = 32'hCAFE_0001; sw_b = 32'h0000_0003; sw_fn = 6'h21;
        #1;
        chk(alu_a == sw_a && alu_b == sw_b && alu_fn == sw_fn, "R8 switches drive ALU",
            {alu_a, alu_fn}, {sw_a, sw_fn});
        @(negedge clk);
        chk(!done && !pass_led && !fail_led, "R8 idle in manual", {done, pass_led, fail_led}, 0);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (4) @(negedge clk);
        chk(!done && !pass_led && !fail_led, "R8 start ignored", {done, pass_led, fail_led}, 0);
        chk(any_fail == 1'b1, "R6 sticky through manual", any_fail, 1);
        auto_mode = 1'b1;
        @(negedge clk);

        // R4 and R6: same answer key passes again, restart clears sticky bit
        run_auto(1'b0);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule